// File: doc/BRIEF.md
# Dual-Channel Fan PWM Controller

Two independent fan drive channels, each generating a pulse-width modulated signal with a fixed period of 256 clocks. The high time of each channel comes from an 8-bit duty value. In manual mode this value is held in a host-writable register. In an automatic mode it is supplied on an input port by an external control loop. A small indexed register port gives the host write and read access to the two duty registers and to one configuration register. The configuration register selects the control mode and the output drive style for each channel.

Each channel drives a data pin and an output-enable, so a pad can be driven push-pull or used as emulated open-drain. A new duty value is applied only when the next period starts, so a period is never cut short or stretched. The all-ones duty code gives a steady high output rather than 255 of 256 clocks.

Top module: `fan_pwm_pair`

## Requirements
- R1: After reset, the duty registers at index 01h (channel 1) and 03h (channel 2) read FFh, the configuration register at index 04h reads 00h, and both outputs drive high with the output-enable asserted.
- R2: For a duty value d with 0 < d < FFh, a channel's level is high for exactly d clocks of every 256-clock period and low for the other clocks.
- R3: A duty value of 00h holds the channel's level low for the whole period.
- R4: A duty value of FFh holds the channel's level high for all 256 clocks of the period.
- R5: Configuration bits 5:0 read back as written, and bits 7:6 always read 0.
- R6: A read of any index other than 01h, 03h or 04h returns 00h. A write to such an index changes no register.
- R7: Configuration bit 0 (channel 1) and bit 1 (channel 2) select the output style. When the bit is 0 (push-pull), the pin carries the level and the output-enable is 1. When the bit is 1 (open-drain), the pin is 0 and the output-enable is 1 only while the level is low.
- R8: Configuration bits 3:2 (channel 1) and 5:4 (channel 2) select the mode: 00 manual, 01 thermal cruise, 10 speed cruise, 11 reserved. In modes 01 and 10 the channel runs from its automatic duty input, and a read of its duty index returns that input.
- R9: Mode 11 behaves as manual mode. The channel uses the register value, and the register value is read back.
- R10: The counter starts at 0 when reset is released and wraps every 256 clocks. The level is high in the first clocks of each period. A duty change takes effect only at the start of the next period.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_idx_i | input | 8 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe, one clock per write |
| reg_rdata_o | output | 8 | Read data for reg_idx_i, combinational |
| auto_duty1_i | input | 8 | Duty computed externally for channel 1 |
| auto_duty2_i | input | 8 | Duty computed externally for channel 2 |
| pwm_o | output | 2 | Pin data, bit 0 is channel 1 |
| pwm_oe_o | output | 2 | Pin output-enable, bit 0 is channel 1 |

## Verification
The bench counts high clocks over whole periods for random duty values, with 00h and FFh mixed in. This separates a correct compare from an off-by-one compare and from a missing full-high special case. Open-drain and push-pull styles are drawn at random for each channel, so a swapped style bit or a wrong output-enable polarity shows up as a bad pin/enable pair. A directed change of duty in the middle of a period checks whether the new value waits for the period boundary. Mode sweeps through automatic, reserved and manual settings show whether the output and the readback follow the external duty or the register.

// File: rtl/fan_pwm_pkg.sv
`timescale 1ns/1ps
package fan_pwm_pkg;
  parameter int unsigned DUTY_W = 8;
  parameter int unsigned IDX_W  = 8;
  parameter int unsigned N_CH   = 2;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned CFG_BITS = N_CH + MODE_W * N_CH;

  typedef enum logic [MODE_W-1:0] {
    MODE_MANUAL  = 2'b00,
    MODE_THERMAL = 2'b01,
    MODE_SPEED   = 2'b10,
    MODE_RSVD    = 2'b11
  } fan_mode_e;

  localparam logic [IDX_W-1:0] IDX_CFG = 8'h04;

  // duty registers sit at odd indices 01h, 03h, ...
  function automatic logic [IDX_W-1:0] duty_idx(int unsigned ch);
    return IDX_W'(2 * ch + 1);
  endfunction

  function automatic logic mode_is_auto(logic [MODE_W-1:0] m);
    return (m == MODE_THERMAL) || (m == MODE_SPEED);
  endfunction
endpackage

// File: rtl/fan_pwm_regs.sv
`timescale 1ns/1ps
module fan_pwm_regs
  import fan_pwm_pkg::*;
#(
  parameter int unsigned DW = fan_pwm_pkg::DUTY_W,
  parameter int unsigned IW = fan_pwm_pkg::IDX_W,
  parameter int unsigned NC = fan_pwm_pkg::N_CH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IW-1:0]               idx_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic                        we_i,
  input  logic [NC-1:0][DW-1:0]       auto_duty_i,
  output logic [DW-1:0]               rdata_o,
  output logic [NC-1:0][DW-1:0]       man_duty_o,
  output logic [NC-1:0][MODE_W-1:0]   mode_o,
  output logic [NC-1:0]               od_o
);
  localparam int unsigned CB = NC + MODE_W * NC;

  logic [NC-1:0][DW-1:0] duty_q;
  logic [CB-1:0]         cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '1;
      cfg_q  <= '0;
    end else if (we_i) begin
      if (idx_i == IDX_CFG) cfg_q <= wdata_i[CB-1:0];
      for (int i = 0; i < NC; i++)
        if (idx_i == duty_idx(i)) duty_q[i] <= wdata_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      od_o[i]       = cfg_q[i];
      mode_o[i]     = cfg_q[NC + MODE_W*i +: MODE_W];
      man_duty_o[i] = duty_q[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_CFG) rdata_o[CB-1:0] = cfg_q;
    for (int i = 0; i < NC; i++)
      if (idx_i == duty_idx(i))
        rdata_o = mode_is_auto(mode_o[i]) ? auto_duty_i[i] : duty_q[i];
  end

  p_cfg_rsv_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == IDX_CFG) |-> (rdata_o[DW-1:CB] == '0));

  p_unused_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i != IDX_CFG && idx_i != duty_idx(0) && idx_i != duty_idx(1)) |-> (rdata_o == '0));
endmodule

// File: rtl/fan_pwm_chan.sv
`timescale 1ns/1ps
module fan_pwm_chan #(
  parameter int unsigned DW = fan_pwm_pkg::DUTY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] duty_i,
  input  logic          od_i,
  output logic          pwm_o,
  output logic          pwm_oe_o
);
  localparam logic [DW-1:0] FULL = '1;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] act_q;
  logic          level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= FULL;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == FULL) act_q <= duty_i;  // reload only at the period wrap
    end
  end

  assign level    = (act_q == FULL) || (cnt_q < act_q);
  assign pwm_o    = od_i ? 1'b0 : level;
  assign pwm_oe_o = od_i ? ~level : 1'b1;

  p_duty_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != FULL) |=> $stable(act_q));

  p_rise_at_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level) |-> (cnt_q == '0));
endmodule

// File: rtl/fan_pwm_pair.sv
`timescale 1ns/1ps
module fan_pwm_pair
  import fan_pwm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_idx_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        reg_we_i,
  output logic [7:0]  reg_rdata_o,
  input  logic [7:0]  auto_duty1_i,
  input  logic [7:0]  auto_duty2_i,
  output logic [1:0]  pwm_o,
  output logic [1:0]  pwm_oe_o
);
  logic [N_CH-1:0][DUTY_W-1:0] auto_duty;
  logic [N_CH-1:0][DUTY_W-1:0] man_duty;
  logic [N_CH-1:0][MODE_W-1:0] mode;
  logic [N_CH-1:0]             od;

  assign auto_duty[0] = auto_duty1_i;
  assign auto_duty[1] = auto_duty2_i;

  fan_pwm_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (reg_idx_i),
    .wdata_i     (reg_wdata_i),
    .we_i        (reg_we_i),
    .auto_duty_i (auto_duty),
    .rdata_o     (reg_rdata_o),
    .man_duty_o  (man_duty),
    .mode_o      (mode),
    .od_o        (od)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [DUTY_W-1:0] sel_duty;
    assign sel_duty = mode_is_auto(mode[i]) ? auto_duty[i] : man_duty[i];

    fan_pwm_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .duty_i   (sel_duty),
      .od_i     (od[i]),
      .pwm_o    (pwm_o[i]),
      .pwm_oe_o (pwm_oe_o[i])
    );

    p_od_pin_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      od[i] |-> !pwm_o[i]);

    p_pp_oe_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !od[i] |-> pwm_oe_o[i]);

    p_auto_readback_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_idx_i == duty_idx(i) && mode_is_auto(mode[i])) |-> (reg_rdata_o == auto_duty[i]));
  end
endmodule

// File: tb/fan_pwm_pair_test.sv
`timescale 1ns/1ps
module fan_pwm_pair_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] reg_idx_i = '0, reg_wdata_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic [7:0] auto_duty1_i = '0, auto_duty2_i = '0;
  logic [1:0] pwm_o, pwm_oe_o;

  int errors = 0, checks = 0, cyc = 0;
  logic [1:0] od_sh = 2'b00;

  fan_pwm_pair uut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    reg_idx_i = idx; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (idx == 8'h04) od_sh = d[1:0];
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk_i);
    reg_idx_i = idx;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk_i); while ((cyc % 256) != p);
  endtask

  function automatic logic lvl(input int ch);
    return od_sh[ch] ? ~pwm_oe_o[ch] : pwm_o[ch];
  endfunction

  function automatic int exp_hi(input logic [7:0] d);
    return (d == 8'hFF) ? 256 : int'(d);
  endfunction

  // wait past a boundary, then count high clocks over one full period
  task automatic measure(output int hi0, output int hi1, output int bad);
    hi0 = 0; hi1 = 0; bad = 0;
    wait_phase(128);
    wait_phase(0);
    for (int k = 0; k < 256; k++) begin
      hi0 += int'(lvl(0));
      hi1 += int'(lvl(1));
      for (int c = 0; c < 2; c++)
        if (od_sh[c] ? pwm_o[c] : !pwm_oe_o[c]) bad++;
      @(negedge clk_i);
    end
  endtask

  task automatic check_pair(input logic [7:0] d0, input logic [7:0] d1, input string req);
    int h0, h1, b;
    measure(h0, h1, b);
    chk(h0 == exp_hi(d0), {req, " ch1 high count"}, h0, exp_hi(d0));
    chk(h1 == exp_hi(d1), {req, " ch2 high count"}, h1, exp_hi(d1));
    chk(b == 0, "R7 pin/oe pairing", b, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h01, r); chk(r == 8'hFF, "R1 duty1 reset", r, 8'hFF);
    rd(8'h03, r); chk(r == 8'hFF, "R1 duty2 reset", r, 8'hFF);
    rd(8'h04, r); chk(r == 8'h00, "R1 cfg reset", r, 8'h00);
    chk(pwm_o == 2'b11 && pwm_oe_o == 2'b11, "R1 outputs after reset", {pwm_o, pwm_oe_o}, 4'hF);
    check_pair(8'hFF, 8'hFF, "R4 reset duty");

    // R3 and R4 extremes, R2 near edges
    wr(8'h01, 8'h00); wr(8'h03, 8'hFF);
    check_pair(8'h00, 8'hFF, "R3/R4");
    wr(8'h01, 8'h01); wr(8'h03, 8'hFE);
    check_pair(8'h01, 8'hFE, "R2 edge");

    // R10 mid-period change waits for boundary
    wr(8'h01, 8'd200); wr(8'h04, 8'h00);
    wait_phase(128); wait_phase(0);
    wait_phase(100);
    wr(8'h01, 8'd50);
    wait_phase(150); chk(pwm_o[0] == 1'b1, "R10 old duty holds", pwm_o[0], 1);
    wait_phase(0);   chk(pwm_o[0] == 1'b1, "R10 period start high", pwm_o[0], 1);
    wait_phase(49);  chk(pwm_o[0] == 1'b1, "R10 last high clock", pwm_o[0], 1);
    wait_phase(50);  chk(pwm_o[0] == 1'b0, "R10 new duty applied", pwm_o[0], 0);

    // R8 automatic modes: ch1 thermal (bits 3:2=01), ch2 speed (bits 5:4=10)
    wr(8'h01, 8'h10); wr(8'h03, 8'h20);
    auto_duty1_i = 8'h40; auto_duty2_i = 8'hC0;
    wr(8'h04, 8'h24);
    rd(8'h01, r); chk(r == 8'h40, "R8 auto readback ch1", r, 8'h40);
    rd(8'h03, r); chk(r == 8'hC0, "R8 auto readback ch2", r, 8'hC0);
    check_pair(8'h40, 8'hC0, "R8 auto drive");

    // R9 reserved mode acts manual
    wr(8'h04, 8'h3C);
    rd(8'h01, r); chk(r == 8'h10, "R9 reserved readback ch1", r, 8'h10);
    rd(8'h03, r); chk(r == 8'h20, "R9 reserved readback ch2", r, 8'h20);
    check_pair(8'h10, 8'h20, "R9 reserved drive");

    // R5 reserved config bits, R7 open-drain on both
    wr(8'h04, 8'hFF);
    rd(8'h04, r); chk(r == 8'h3F, "R5 cfg readback", r, 8'h3F);
    check_pair(8'h10, 8'h20, "R7 open-drain");

    // R6 unused indices
    wr(8'h02, 8'h55); wr(8'h00, 8'hAA); wr(8'h05, 8'h77);
    rd(8'h02, r); chk(r == 8'h00, "R6 index 02", r, 0);
    rd(8'h00, r); chk(r == 8'h00, "R6 index 00", r, 0);
    rd(8'hFF, r); chk(r == 8'h00, "R6 index FF", r, 0);
    rd(8'h01, r); chk(r == 8'h10, "R6 duty1 untouched", r, 8'h10);
    rd(8'h03, r); chk(r == 8'h20, "R6 duty2 untouched", r, 8'h20);
    rd(8'h04, r); chk(r == 8'h3F, "R6 cfg untouched", r, 8'h3F);

    // R2/R7 random duties and styles in manual mode
    for (int it = 0; it < 14; it++) begin
      logic [7:0] d0, d1, cfg;
      d0 = 8'($urandom); d1 = 8'($urandom);
      if (it == 3) d0 = 8'h00;
      if (it == 5) d1 = 8'hFF;
      cfg = {6'b0, 2'($urandom)};
      wr(8'h04, cfg); wr(8'h01, d0); wr(8'h03, d1);
      rd(8'h01, r); chk(r == d0, "R2 manual readback", r, d0);
      check_pair(d0, d1, "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule